// File: doc/BRIEF.md
# Received Pause Timer and Transmit Inhibit

This block covers the receive half of full-duplex MAC flow control. It watches the received frame byte stream, which is qualified by start, valid, end and good-CRC flags. It recognises pause control frames and takes their 16-bit pause value. While a nonzero pause value is counting down, it stops the transmitter from starting new frames. A frame that is already on the wire is allowed to finish.

The block also owns the host's transmit-request bit. The host raises the bit with a one-cycle set pulse. While the link is paused, the start of transmission is held back without the host being told. When the pause ends, the block issues one start pulse to the transmitter. It clears the request bit only when the transmitter reports that the frame is done.

At the end of each received frame the block reports that the frame finished. It also says whether the host should discard the frame. Pause frames are absorbed unless pass-all mode is on, in which case they are handed to the host to interpret.

Top module: `pause_rx_gate`

## Requirements
- R1: A frame counts as a pause frame only if all of the following hold:
  - it is at least 18 bytes long;
  - byte indexes 0..5 (counted from the byte flagged as frame start) are 01 80 C2 00 00 01;
  - bytes 12..13 are 88 08;
  - bytes 14..15 are 00 01.
  Bytes 6..11 are not compared. The pause value is byte 16 (upper half) followed by byte 17 (lower half).
- R2: A pause frame takes effect only if `rx_crc_ok` is high with its last byte and `rx_pause_en` is high. When it takes effect, `paused` rises on the second clock edge after that last byte. Otherwise `paused` is unchanged.
- R3: A nonzero pause value N holds `paused` high for exactly N × `QUANTUM_CYC` clock cycles.
- R4: A pause frame with value 0000h drops `paused` on the same edge at which a nonzero value would have loaded.
- R5: Each pause frame that takes effect replaces any remaining pause count with its own value.
- R6: `tx_start` is high for one cycle when a request is pending, no frame is being transmitted and `paused` is low. It is never high while `paused` is high. A request made during a pause starts in the first cycle with `paused` low.
- R7: `tx_req` rises on the clock edge after a `tx_req_set` pulse. It stays high until the edge after `tx_done`, and then goes low. Each request gives exactly one `tx_start`.
- R8: A pause that arrives after `tx_start` does not disturb the frame in flight. No new `tx_start` is given before `tx_done`.
- R9: `rx_done` pulses for one cycle, one cycle after each last byte. `rx_drop` pulses with it when the frame is a pause frame (by R1) and `pass_all` is low. With `pass_all` high, or for any other frame, `rx_drop` stays low.
- R10: After reset, `paused`, `tx_req`, `tx_start`, `rx_done` and `rx_drop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pause_en | input | 1 | Allow received pause frames to inhibit transmission |
| pass_all | input | 1 | Hand pause frames to the host instead of absorbing them |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | First byte of a frame (with `rx_valid`) |
| rx_eof | input | 1 | Last byte of a frame (with `rx_valid`) |
| rx_crc_ok | input | 1 | Frame CRC good, sampled with the last byte |
| rx_data | input | 8 | Received byte |
| tx_req_set | input | 1 | Host pulse that raises the transmit request |
| tx_done | input | 1 | Transmitter pulse: the started frame has been sent |
| tx_req | output | 1 | Host-visible transmit-request bit |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| paused | output | 1 | Pause count is running |
| rx_done | output | 1 | End-of-frame pulse |
| rx_drop | output | 1 | With `rx_done`: host should discard the frame |

## Verification
The recogniser is tried with every compared header byte corrupted in turn. It is also tried with each ignored source byte corrupted, and with frame lengths either side of the 18-byte minimum. These patterns separate a correct byte map from one that is off by one position or too permissive.

The timer is swept over several small values, and over 0001h against 0100h. This tells apart exact N-quanta counting, a byte-order swap, reload and zero release. Bad-CRC and disabled frames show that the timer is not touched.

Transmit requests are placed before a pause, during a pause and during an active frame. This separates holding a request from aborting a frame, and clearing the request on start from clearing it on done.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int BYTE_W     = 8;
    localparam int VAL_W      = 16;
    localparam int IDX_W      = 5;
    localparam int IDX_MAX    = (1 << IDX_W) - 1;
    localparam int VAL_HI_POS = 16;
    localparam int VAL_LO_POS = 17;

    // {compare, expected byte} for each header position of a pause frame
    function automatic logic [BYTE_W:0] hdr_ref(input logic [IDX_W-1:0] pos);
        case (pos)
            5'd0:    hdr_ref = {1'b1, 8'h01};
            5'd1:    hdr_ref = {1'b1, 8'h80};
            5'd2:    hdr_ref = {1'b1, 8'hC2};
            5'd3:    hdr_ref = {1'b1, 8'h00};
            5'd4:    hdr_ref = {1'b1, 8'h00};
            5'd5:    hdr_ref = {1'b1, 8'h01};
            5'd12:   hdr_ref = {1'b1, 8'h88};
            5'd13:   hdr_ref = {1'b1, 8'h08};
            5'd14:   hdr_ref = {1'b1, 8'h00};
            5'd15:   hdr_ref = {1'b1, 8'h01};
            default: hdr_ref = {1'b0, 8'h00};
        endcase
    endfunction
endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
    import pause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_crc_ok,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              frm_end,
    output logic              frm_pause,
    output logic              frm_crc_good,
    output logic [VAL_W-1:0]  frm_val
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             match;
        logic [VAL_W-1:0] val;
        logic             done;
        logic             is_pause;
        logic             crc_good;
    } prs_t;

    prs_t prs_d, prs_q;

    always_comb begin
        logic [IDX_W-1:0] pos;
        logic             hit;
        logic [BYTE_W:0]  ref_b;
        logic [VAL_W-1:0] v;
        prs_d      = prs_q;
        prs_d.done = 1'b0;
        pos        = '0;
        hit        = 1'b0;
        ref_b      = '0;
        v          = '0;
        if (rx_valid) begin
            pos   = rx_sof ? '0 : prs_q.idx;
            hit   = rx_sof ? 1'b1 : prs_q.match;
            ref_b = hdr_ref(pos);
            if (ref_b[BYTE_W] && (ref_b[BYTE_W-1:0] != rx_data)) begin
                hit = 1'b0;
            end
            v = rx_sof ? '0 : prs_q.val;
            if (pos == IDX_W'(VAL_HI_POS)) v[VAL_W-1:BYTE_W] = rx_data;
            if (pos == IDX_W'(VAL_LO_POS)) v[BYTE_W-1:0]     = rx_data;
            prs_d.idx   = (pos == IDX_W'(IDX_MAX)) ? pos : pos + 1'b1;
            prs_d.match = hit;
            prs_d.val   = v;
            if (rx_eof) begin
                prs_d.done     = 1'b1;
                prs_d.is_pause = hit && (pos >= IDX_W'(VAL_LO_POS));
                prs_d.crc_good = rx_crc_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prs_q <= '0;
        else        prs_q <= prs_d;
    end

    assign frm_end      = prs_q.done;
    assign frm_pause    = prs_q.is_pause;
    assign frm_crc_good = prs_q.crc_good;
    assign frm_val      = prs_q.val;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
    import pause_pkg::*;
#(
    parameter int QUANTUM_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] load_val,
    output logic             paused
);
    localparam int QW = (QUANTUM_CYC > 1) ? $clog2(QUANTUM_CYC) : 1;
    localparam logic [QW-1:0] Q_LAST = QW'(QUANTUM_CYC - 1);

    typedef struct packed {
        logic [VAL_W-1:0] quanta;
        logic [QW-1:0]    sub;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.quanta = load_val;
            tmr_d.sub    = Q_LAST;
        end else if (tmr_q.quanta != '0) begin
            if (tmr_q.sub == '0) begin
                tmr_d.quanta = tmr_q.quanta - 1'b1;
                tmr_d.sub    = Q_LAST;
            end else begin
                tmr_d.sub = tmr_q.sub - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign paused = (tmr_q.quanta != '0);
endmodule

// File: rtl/tx_req_gate.sv
module tx_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic tx_done,
    input  logic paused,
    output logic tx_req,
    output logic tx_start
);
    typedef struct packed {
        logic req;
        logic act;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  go;

    assign go = gate_q.req && !gate_q.act && !paused;

    always_comb begin
        gate_d = gate_q;
        if (req_set && !gate_q.req) gate_d.req = 1'b1;
        if (go)                     gate_d.act = 1'b1;
        if (tx_done && gate_q.act) begin
            gate_d.act = 1'b0;
            gate_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign tx_req   = gate_q.req;
    assign tx_start = go;
endmodule

// File: rtl/pause_rx_gate.sv
module pause_rx_gate
    import pause_pkg::*;
#(
    parameter int QUANTUM_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pause_en,
    input  logic              pass_all,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_crc_ok,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_req_set,
    input  logic              tx_done,
    output logic              tx_req,
    output logic              tx_start,
    output logic              paused,
    output logic              rx_done,
    output logic              rx_drop
);
    logic             f_end, f_pause, f_crc;
    logic [VAL_W-1:0] f_val;
    logic             apply;

    pause_frame_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_ok(rx_crc_ok), .rx_data(rx_data),
        .frm_end(f_end), .frm_pause(f_pause),
        .frm_crc_good(f_crc), .frm_val(f_val)
    );

    assign apply = f_end && f_pause && f_crc && rx_pause_en;

    pause_quanta_timer #(.QUANTUM_CYC(QUANTUM_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(apply), .load_val(f_val), .paused(paused)
    );

    tx_req_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .req_set(tx_req_set), .tx_done(tx_done), .paused(paused),
        .tx_req(tx_req), .tx_start(tx_start)
    );

    assign rx_done = f_end;
    assign rx_drop = f_end && f_pause && !pass_all;
endmodule

// File: rtl/pause_rx_gate_chk.sv
module pause_rx_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pause_en,
    input logic pass_all,
    input logic rx_valid,
    input logic rx_eof,
    input logic tx_req_set,
    input logic tx_done,
    input logic tx_req,
    input logic tx_start,
    input logic paused,
    input logic rx_done,
    input logic rx_drop
);
    logic in_flight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        in_flight <= 1'b0;
        else if (tx_done)  in_flight <= 1'b0;
        else if (tx_start) in_flight <= 1'b1;
    end

    AST_START_NOT_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !paused); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> tx_req); // R7
    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_req && !tx_req_set) |=> !tx_req); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !tx_start); // R8
    AST_PAUSE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(rx_done && rx_pause_en)); // R2
    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rx_valid && rx_eof)); // R9
    AST_DROP_ONLY_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> (rx_done && !pass_all)); // R9
endmodule

bind pause_rx_gate pause_rx_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_pause_en(rx_pause_en), .pass_all(pass_all),
    .rx_valid(rx_valid), .rx_eof(rx_eof), .tx_req_set(tx_req_set),
    .tx_done(tx_done), .tx_req(tx_req), .tx_start(tx_start),
    .paused(paused), .rx_done(rx_done), .rx_drop(rx_drop)
);

// File: tb/pause_rx_gate_bench.sv
`timescale 1ns/1ps
module pause_rx_gate_bench;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pause_en = 1'b1, pass_all = 1'b0;
    logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_req_set = 1'b0, tx_done = 1'b0;
    logic       tx_req, tx_start, paused, rx_done, rx_drop;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic got_done, got_drop;

    always #10 clk = ~clk;

    pause_rx_gate #(.QUANTUM_CYC(Q)) u_pause_rx_gate (
        .clk(clk), .rst_n(rst_n), .rx_pause_en(rx_pause_en), .pass_all(pass_all),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
        .rx_data(rx_data), .tx_req_set(tx_req_set), .tx_done(tx_done),
        .tx_req(tx_req), .tx_start(tx_start), .paused(paused),
        .rx_done(rx_done), .rx_drop(rx_drop)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input int i, input logic [15:0] v);
        case (i)
            0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
            3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
            12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
            16: return v[15:8];
            17: return v[7:0];
            default: return (i >= 6 && i <= 11) ? 8'(8'h10 + i) : 8'hA5;
        endcase
    endfunction

    // returns at the negedge where rx_done is expected high
    task automatic send(input int len, input logic [15:0] v, input int bad, input logic crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len - 1);
            rx_crc_ok = crc;
            rx_data   = frame_byte(i, v) ^ ((i == bad) ? 8'h01 : 8'h00);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
        got_done = rx_done;
        got_drop = rx_drop;
    endtask

    // from the rx_done negedge: cycles with paused high
    task automatic measure(output int n);
        n = 0;
        @(negedge clk);
        while (paused && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (paused && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R10 paused", paused, 0);
        check("R10 tx_req", tx_req, 0);
        check("R10 tx_start", tx_start, 0);
        check("R10 rx_done", rx_done, 0);
        check("R10 rx_drop", rx_drop, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: duration sweep
        for (int v = 1; v <= 6; v++) begin
            send(18, 16'(v), -1, 1'b1);
            check("R9 done", got_done, 1);
            check("R9 drop", got_drop, 1);
            check("R2 not yet", paused, 0);
            measure(n);
            check("R3 duration", n, v * Q);
        end

        // R1: byte order
        send(18, 16'h0100, -1, 1'b1);
        measure(n);
        check("R1 msb first", n, 256 * Q);

        // R1: header corruption sweep
        for (int b = 0; b < 16; b++) begin
            send(18, 16'h0001, b, 1'b1);
            measure(n);
            check("R1 header byte", n, (b >= 6 && b <= 11) ? Q : 0);
            check("R9 drop header", got_drop, (b >= 6 && b <= 11) ? 1 : 0);
        end

        // R1: length boundary
        for (int len = 16; len <= 20; len++) begin
            send(len, 16'h0002, -1, 1'b1);
            measure(n);
            check("R1 length", n, (len >= 18) ? 2 * Q : 0);
        end

        // R2: bad CRC and disabled
        send(18, 16'h0003, -1, 1'b0);
        measure(n);
        check("R2 bad crc", n, 0);
        rx_pause_en = 1'b0;
        send(18, 16'h0003, -1, 1'b1);
        measure(n);
        check("R2 disabled", n, 0);
        rx_pause_en = 1'b1;

        // R9: pass-all
        pass_all = 1'b1;
        send(18, 16'h0001, -1, 1'b1);
        check("R9 pass_all done", got_done, 1);
        check("R9 pass_all drop", got_drop, 0);
        measure(n);
        check("R3 pass_all still pauses", n, Q);
        pass_all = 1'b0;

        // R4: zero release
        send(18, 16'd200, -1, 1'b1);
        repeat (10) @(negedge clk);
        check("R4 running", paused, 1);
        send(18, 16'h0000, -1, 1'b1);
        check("R4 before load", paused, 1);
        @(negedge clk);
        check("R4 released", paused, 0);

        // R5: reload replaces
        send(18, 16'd100, -1, 1'b1);
        repeat (20) @(negedge clk);
        send(18, 16'd2, -1, 1'b1);
        measure(n);
        check("R5 reload", n, 2 * Q);

        // R6/R7: request held through pause
        send(18, 16'd3, -1, 1'b1);
        tx_req_set = 1'b1;
        @(negedge clk);
        tx_req_set = 1'b0;
        check("R7 req set", tx_req, 1);
        n = 0;
        while (!tx_start && n < 100) begin
            if (!paused) break;
            n++;
            @(negedge clk);
        end
        check("R6 held cycles", n, 3 * Q);
        check("R6 start after pause", tx_start, 1);
        @(negedge clk);
        check("R7 single start", tx_start, 0);
        check("R7 req kept until done", tx_req, 1);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check("R7 req cleared", tx_req, 0);

        // R6: unpaused request starts at once
        tx_req_set = 1'b1;
        @(negedge clk);
        tx_req_set = 1'b0;
        check("R6 immediate start", tx_start, 1);
        @(negedge clk);

        // R8: pause while frame in flight
        send(18, 16'd2, -1, 1'b1);
        n = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            n += tx_start;
        end
        check("R8 no restart", n, 0);
        check("R8 req during flight", tx_req, 1);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check("R8 req cleared on done", tx_req, 0);
        @(negedge clk);
        check("R7 no start without req", tx_start, 0);
        drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule